// File: doc/BRIEF.md
# Three-state snooping coherence controller

This block keeps one processor's small direct-mapped cache coherent with peer caches on a shared snooping bus. Each cache frame holds a tag, a data word and one of three states: Invalid, Shared, or Exclusive. Exclusive is a single state for a line that this cache alone owns, and that line may be read or written locally with no bus traffic. Because Exclusive does not record whether the line was changed, an owned line is always treated as possibly changed. Its data goes back to memory only when it is evicted. It is never written back when a peer's write takes it away.

The processor side takes one request at a time: a read, a write or an evict. The controller stays busy until that request finishes. On the bus side it requests at most one transaction at a time: a read, a read-for-ownership that invalidates other copies, or a writeback. The transaction completes in the cycle the bus raises the acknowledge. That same cycle, the bus must show the transaction to every other cache on the snoop port, return their combined shared flag, and return either supplied data or memory data.

When a cache supplies data on a snooped read, the bus also writes that data into memory. This keeps memory correct once both copies are Shared and are later dropped with no writeback. A probe port reports the state that a given address holds in this cache.

Top module: `coh_ctrl`

## Requirements
- R1: After reset every frame is Invalid: the probe reports 2'b00 for any address (encoding Invalid=2'b00, Shared=2'b01, Exclusive=2'b10), cpu_ready is high, and bus_req_valid is low.
- R2: A read of an address held in Shared or Exclusive, or a write of an address held in Exclusive, completes with no bus request. A write stores cpu_wdata and leaves the line Exclusive.
- R3: A read miss issues a bus read (cmd 2'b01). The line fills with bus_resp_data and becomes Exclusive when bus_resp_shared is low, or Shared when it is high. cpu_rdata returns the filled word.
- R4: A write to an address held in Shared or missing issues a read-for-ownership (cmd 2'b10). The line then holds cpu_wdata in Exclusive, and every peer copy becomes Invalid.
- R5: A snooped read (cmd 2'b01) that hits an Exclusive line raises snp_shared and snp_supply, drives the line's data on snp_data, and moves the line to Shared. A snooped read that hits a Shared line raises only snp_shared.
- R6: A snooped read-for-ownership (cmd 2'b10) that hits a Shared or Exclusive line moves it to Invalid. The snooping cache issues no writeback or other bus request for it.
- R7: When an Exclusive frame must be reused for another tag, or an Exclusive line is evicted (op 2'b10), a writeback (cmd 2'b11) of the line's own address and data comes first. Only after it does the frame become Invalid or refill. Memory then returns the written word.
- R8: Evicting a Shared line, or evicting an address that is not present, finishes with no bus request. The line becomes Invalid and peer copies are untouched.
- R9: From acceptance until cpu_done, cpu_ready stays low and the request waits without limit for bus_ack. While cpu_ready is high, no bus request is raised.
- R10: Across caches on one bus, no address is Exclusive in one cache while it is Shared or Exclusive in another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present; taken when cpu_ready is high |
| cpu_op | input | 2 | 00 read, 01 write, 10 evict |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle pulse when the request finishes |
| cpu_rdata | output | DATA_W | Read result, valid with cpu_done |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 01 read, 10 read-for-ownership, 11 writeback |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_data | output | DATA_W | Writeback data |
| bus_ack | input | 1 | Transaction performed this cycle |
| bus_resp_data | input | DATA_W | Fill data, valid with bus_ack |
| bus_resp_shared | input | 1 | A peer holds the address, valid with bus_ack |
| snp_valid | input | 1 | Peer transaction observed this cycle |
| snp_cmd | input | 2 | Observed command, same code as bus_req_cmd |
| snp_addr | input | ADDR_W | Observed address |
| snp_shared | output | 1 | This cache holds the snooped address for a read |
| snp_supply | output | 1 | This cache supplies data for the snooped read |
| snp_data | output | DATA_W | Supplied data |
| prb_addr | input | ADDR_W | Address to inspect |
| prb_state | output | 2 | State of prb_addr in this cache |

## Verification
Some rules are checked on every cycle. A writeback may leave only from an Exclusive frame, and no bus request may appear while the controller is idle. After a fill, the line's state must follow the shared flag. A frame must be Exclusive after an ownership transaction and Invalid after a peer's ownership snoop, and a line that supplied data must end up Shared.

Other behaviours only the two-cache scenarios can show. Replaced lines must have reached memory: a peer reading that address later sees the written value. Peer copies must vanish on a write. Hits and silent evictions must produce no transaction. The cross-cache invariant must hold at each step.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10
  } line_state_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'b00,
    BC_RD   = 2'b01,
    BC_RDX  = 2'b10,
    BC_WB   = 2'b11
  } bus_cmd_e;

  typedef enum logic [1:0] {
    CO_RD = 2'b00,
    CO_WR = 2'b01,
    CO_EV = 2'b10
  } cpu_op_e;

  // a frame holds usable data in Shared and Exclusive
  function automatic logic line_valid(input logic [1:0] st);
    return (st == LS_SHR) || (st == LS_EXC);
  endfunction

  // state a read fill lands in, decided by the peers' shared flag
  function automatic logic [1:0] fill_state(input logic peer_shared);
    return peer_shared ? LS_SHR : LS_EXC;
  endfunction

  // state after a peer transaction hits a valid frame
  function automatic logic [1:0] snoop_next(input logic [1:0] st, input logic [1:0] cmd);
    logic [1:0] nxt;
    nxt = st;
    if (cmd == BC_RD)  nxt = LS_SHR;
    if (cmd == BC_RDX) nxt = LS_INV;
    return nxt;
  endfunction

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IDX_W-1:0]             req_idx,
  output logic [1:0]                   req_state,
  output logic [TAG_W-1:0]             req_tag,
  output logic [DATA_W-1:0]            req_data,
  input  logic [IDX_W-1:0]             snp_idx,
  output logic [1:0]                   snp_state,
  output logic [TAG_W-1:0]             snp_tag,
  output logic [DATA_W-1:0]            snp_data,
  input  logic [IDX_W-1:0]             prb_idx,
  output logic [1:0]                   prb_state,
  output logic [TAG_W-1:0]             prb_tag,
  input  logic                         lw_en,
  input  logic [IDX_W-1:0]             lw_idx,
  input  logic [1:0]                   lw_state,
  input  logic [TAG_W-1:0]             lw_tag,
  input  logic                         lw_data_en,
  input  logic [DATA_W-1:0]            lw_data,
  input  logic                         sw_en,
  input  logic [IDX_W-1:0]             sw_idx,
  input  logic [1:0]                   sw_state,
  output logic [(1<<IDX_W)-1:0][1:0]   st_all
);

  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0][TAG_W-1:0]  tag_all;
  logic [LINES-1:0][DATA_W-1:0] data_all;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [1:0]        st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic              lw_sel;
    logic              sw_sel;

    assign lw_sel = lw_en && (lw_idx == IDX_W'(i));
    assign sw_sel = sw_en && (sw_idx == IDX_W'(i));

    // local updates and snoop updates never target one frame together
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q <= LS_INV;
      else if (lw_sel) st_q <= lw_state;
      else if (sw_sel) st_q <= sw_state;
    end

    always_ff @(posedge clk) begin
      if (lw_sel) begin
        tag_q <= lw_tag;
        if (lw_data_en) data_q <= lw_data;
      end
    end

    assign st_all[i]   = st_q;
    assign tag_all[i]  = tag_q;
    assign data_all[i] = data_q;
  end

  assign req_state = st_all[req_idx];
  assign req_tag   = tag_all[req_idx];
  assign req_data  = data_all[req_idx];
  assign snp_state = st_all[snp_idx];
  assign snp_tag   = tag_all[snp_idx];
  assign snp_data  = data_all[snp_idx];
  assign prb_state = st_all[prb_idx];
  assign prb_tag   = tag_all[prb_idx];

endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
  import coh_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag_in,
  input  logic [1:0]        ln_state,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              snp_hit,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data,
  output logic [1:0]        upd_state
);

  logic acts;

  // writebacks seen on the bus need no reaction
  assign acts       = (snp_cmd == BC_RD) || (snp_cmd == BC_RDX);
  assign snp_hit    = snp_valid && acts && line_valid(ln_state) && (ln_tag == snp_tag_in);
  assign snp_shared = snp_hit && (snp_cmd == BC_RD);
  assign snp_supply = snp_shared && (ln_state == LS_EXC);
  assign snp_data   = snp_supply ? ln_data : '0;
  assign upd_state  = snoop_next(ln_state, snp_cmd);

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_req_valid,
  input  logic [1:0]               cpu_op,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  output logic                     cpu_ready,
  output logic                     cpu_done,
  output logic [DATA_W-1:0]        cpu_rdata,
  input  logic [1:0]               ln_state,
  input  logic [ADDR_W-IDX_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0]        ln_data,
  input  logic                     local_stall,
  output logic                     bus_req_valid,
  output logic [1:0]               bus_req_cmd,
  output logic [ADDR_W-1:0]        bus_req_addr,
  output logic [DATA_W-1:0]        bus_req_data,
  input  logic                     bus_ack,
  input  logic [DATA_W-1:0]        bus_resp_data,
  input  logic                     bus_resp_shared,
  output logic [IDX_W-1:0]         req_idx,
  output logic                     lw_en,
  output logic [1:0]               lw_state,
  output logic [ADDR_W-IDX_W-1:0]  lw_tag,
  output logic                     lw_data_en,
  output logic [DATA_W-1:0]        lw_data,
  output logic                     ev_hit,
  output logic                     ev_victim_dirty
);

  localparam int TAG_W = ADDR_W - IDX_W;

  logic              busy_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  logic [TAG_W-1:0]  want_tag;
  logic [1:0]        cmd;
  logic              fin_local;
  logic              fin_bus;
  logic [DATA_W-1:0] next_rdata;

  assign want_tag        = addr_q[ADDR_W-1:IDX_W];
  assign req_idx         = addr_q[IDX_W-1:0];
  assign ev_hit          = line_valid(ln_state) && (ln_tag == want_tag);
  assign ev_victim_dirty = (ln_state == LS_EXC) && (ln_tag != want_tag);

  always_comb begin
    cmd        = BC_NONE;
    fin_local  = 1'b0;
    fin_bus    = 1'b0;
    lw_en      = 1'b0;
    lw_state   = LS_INV;
    lw_data_en = 1'b0;
    lw_data    = wdata_q;
    next_rdata = ln_data;
    if (busy_q) begin
      unique case (op_q)
        CO_RD: begin
          if (ev_hit)               fin_local = 1'b1;
          else if (ev_victim_dirty) cmd = BC_WB;
          else                      cmd = BC_RD;
        end
        CO_WR: begin
          if (ev_hit && ln_state == LS_EXC) begin
            fin_local  = 1'b1;
            lw_en      = 1'b1;
            lw_state   = LS_EXC;
            lw_data_en = 1'b1;
          end else if (ev_victim_dirty) cmd = BC_WB;
          else                          cmd = BC_RDX;
        end
        CO_EV: begin
          if (ev_hit && ln_state == LS_EXC) cmd = BC_WB;
          else begin
            fin_local = 1'b1;
            lw_en     = ev_hit;
          end
        end
        default: fin_local = 1'b1;
      endcase
      // a peer transaction on this very frame goes first
      if (local_stall) begin
        fin_local  = 1'b0;
        lw_en      = 1'b0;
        lw_data_en = 1'b0;
      end
      if (bus_ack && cmd != BC_NONE) begin
        lw_en = 1'b1;
        unique case (cmd)
          BC_WB: begin
            lw_state = LS_INV;
            fin_bus  = (op_q == CO_EV);
          end
          BC_RD: begin
            lw_state   = fill_state(bus_resp_shared);
            lw_data_en = 1'b1;
            lw_data    = bus_resp_data;
            next_rdata = bus_resp_data;
            fin_bus    = 1'b1;
          end
          default: begin
            lw_state   = LS_EXC;
            lw_data_en = 1'b1;
            fin_bus    = 1'b1;
          end
        endcase
      end
    end
  end

  assign lw_tag        = want_tag;
  assign bus_req_valid = (cmd != BC_NONE);
  assign bus_req_cmd   = cmd;
  assign bus_req_addr  = (cmd == BC_WB) ? {ln_tag, req_idx} : addr_q;
  assign bus_req_data  = ln_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      op_q    <= CO_RD;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && cpu_req_valid) begin
        busy_q  <= 1'b1;
        op_q    <= cpu_op;
        addr_q  <= cpu_addr;
        wdata_q <= cpu_wdata;
      end else if (busy_q && (fin_local || fin_bus)) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        rdata_q <= (op_q == CO_RD) ? next_rdata : '0;
      end
    end
  end

  assign cpu_ready = !busy_q;
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !bus_req_valid) else $error("bus request while idle"); // R9

endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_data,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_resp_data,
  input  logic              bus_resp_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data,
  input  logic [ADDR_W-1:0] prb_addr,
  output logic [1:0]        prb_state
);

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [IDX_W-1:0]        req_idx;
  logic [1:0]              rq_state;
  logic [TAG_W-1:0]        rq_tag;
  logic [DATA_W-1:0]       rq_data;
  logic [IDX_W-1:0]        snp_idx;
  logic [1:0]              sn_state;
  logic [TAG_W-1:0]        sn_tag;
  logic [DATA_W-1:0]       sn_data;
  logic [1:0]              pb_state;
  logic [TAG_W-1:0]        pb_tag;
  logic                    lw_en;
  logic [1:0]              lw_state;
  logic [TAG_W-1:0]        lw_tag;
  logic                    lw_data_en;
  logic [DATA_W-1:0]       lw_data;
  logic                    snp_hit;
  logic [1:0]              snp_upd;
  logic                    local_stall;
  logic                    ev_hit;
  logic                    ev_victim_dirty;
  logic [LINES-1:0][1:0]   st_all;

  assign snp_idx     = snp_addr[IDX_W-1:0];
  assign local_stall = snp_hit && (snp_idx == req_idx);

  coh_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_idx    (req_idx),
    .req_state  (rq_state),
    .req_tag    (rq_tag),
    .req_data   (rq_data),
    .snp_idx    (snp_idx),
    .snp_state  (sn_state),
    .snp_tag    (sn_tag),
    .snp_data   (sn_data),
    .prb_idx    (prb_addr[IDX_W-1:0]),
    .prb_state  (pb_state),
    .prb_tag    (pb_tag),
    .lw_en      (lw_en),
    .lw_idx     (req_idx),
    .lw_state   (lw_state),
    .lw_tag     (lw_tag),
    .lw_data_en (lw_data_en),
    .lw_data    (lw_data),
    .sw_en      (snp_hit),
    .sw_idx     (snp_idx),
    .sw_state   (snp_upd),
    .st_all     (st_all)
  );

  coh_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_tag_in (snp_addr[ADDR_W-1:IDX_W]),
    .ln_state   (sn_state),
    .ln_tag     (sn_tag),
    .ln_data    (sn_data),
    .snp_hit    (snp_hit),
    .snp_shared (snp_shared),
    .snp_supply (snp_supply),
    .snp_data   (snp_data),
    .upd_state  (snp_upd)
  );

  coh_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_req_valid   (cpu_req_valid),
    .cpu_op          (cpu_op),
    .cpu_addr        (cpu_addr),
    .cpu_wdata       (cpu_wdata),
    .cpu_ready       (cpu_ready),
    .cpu_done        (cpu_done),
    .cpu_rdata       (cpu_rdata),
    .ln_state        (rq_state),
    .ln_tag          (rq_tag),
    .ln_data         (rq_data),
    .local_stall     (local_stall),
    .bus_req_valid   (bus_req_valid),
    .bus_req_cmd     (bus_req_cmd),
    .bus_req_addr    (bus_req_addr),
    .bus_req_data    (bus_req_data),
    .bus_ack         (bus_ack),
    .bus_resp_data   (bus_resp_data),
    .bus_resp_shared (bus_resp_shared),
    .req_idx         (req_idx),
    .lw_en           (lw_en),
    .lw_state        (lw_state),
    .lw_tag          (lw_tag),
    .lw_data_en      (lw_data_en),
    .lw_data         (lw_data),
    .ev_hit          (ev_hit),
    .ev_victim_dirty (ev_victim_dirty)
  );

  assign prb_state = (line_valid(pb_state) && pb_tag == prb_addr[ADDR_W-1:IDX_W]) ? pb_state : LS_INV;

  AST_WB_FROM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_cmd == BC_WB) |-> (rq_state == LS_EXC && !ev_hit || ev_hit && rq_state == LS_EXC))
    else $error("writeback from a frame that is not owned"); // R7

  AST_FILL_FOLLOWS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && bus_req_cmd == BC_RD) |=>
      st_all[$past(req_idx)] == ($past(bus_resp_shared) ? LS_SHR : LS_EXC))
    else $error("fill state disagrees with shared flag"); // R3

  AST_OWN_AFTER_RDX: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && bus_req_cmd == BC_RDX) |=> st_all[$past(req_idx)] == LS_EXC)
    else $error("ownership transaction left frame not owned"); // R4

  AST_SNOOP_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && snp_cmd == BC_RDX) |=> st_all[$past(snp_idx)] == LS_INV)
    else $error("peer ownership left a live copy"); // R6

  AST_SUPPLIER_SHARES: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |=> st_all[$past(snp_idx)] == LS_SHR)
    else $error("supplier did not drop to shared"); // R5

  AST_SNOOP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && snp_cmd == BC_RDX && cpu_ready) |-> !bus_req_valid)
    else $error("snoop invalidation caused a bus request"); // R6

endmodule

// File: tb/coh_ctrl_tb.sv
module coh_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NV = 18;

  typedef struct packed {
    logic          who;      // 0 = cache A, 1 = cache B
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          chk_rd;
    logic [DW-1:0] exp_rd;
    logic [1:0]    exp_sa;
    logic [1:0]    exp_sb;
    logic [1:0]    exp_nbus;
  } vec_t;

  // memory starts as 16'h1000 + address; states 00 I, 01 S, 10 E
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 8'h04, 16'h0000, 1'b1, 16'h1004, 2'b10, 2'b00, 2'd1}, // R3 alone -> E
    '{1'b1, 2'd0, 8'h04, 16'h0000, 1'b1, 16'h1004, 2'b01, 2'b01, 2'd1}, // R5 R3 supplied, shared
    '{1'b0, 2'd1, 8'h04, 16'hBEEF, 1'b0, 16'h0000, 2'b10, 2'b00, 2'd1}, // R4 R6 upgrade
    '{1'b0, 2'd0, 8'h04, 16'h0000, 1'b1, 16'hBEEF, 2'b10, 2'b00, 2'd0}, // R2 read hit
    '{1'b1, 2'd0, 8'h04, 16'h0000, 1'b1, 16'hBEEF, 2'b01, 2'b01, 2'd1}, // R5 supply new value
    '{1'b1, 2'd1, 8'h04, 16'h1111, 1'b0, 16'h0000, 2'b00, 2'b10, 2'd1}, // R4 R6 peer write
    '{1'b0, 2'd0, 8'h08, 16'h0000, 1'b1, 16'h1008, 2'b10, 2'b00, 2'd1}, // R3 no tag match on peer
    '{1'b0, 2'd1, 8'h08, 16'h2222, 1'b0, 16'h0000, 2'b10, 2'b00, 2'd0}, // R2 write hit
    '{1'b0, 2'd0, 8'h0C, 16'h0000, 1'b1, 16'h100C, 2'b10, 2'b00, 2'd2}, // R7 replace owned
    '{1'b1, 2'd0, 8'h08, 16'h0000, 1'b1, 16'h2222, 2'b00, 2'b10, 2'd2}, // R7 memory has 2222
    '{1'b0, 2'd0, 8'h04, 16'h0000, 1'b1, 16'h1111, 2'b10, 2'b00, 2'd2}, // R7 memory has 1111
    '{1'b0, 2'd2, 8'h04, 16'h0000, 1'b0, 16'h0000, 2'b00, 2'b00, 2'd1}, // R7 evict owned
    '{1'b0, 2'd0, 8'h04, 16'h0000, 1'b1, 16'h1111, 2'b10, 2'b00, 2'd1}, // R7 evicted data kept
    '{1'b1, 2'd0, 8'h04, 16'h0000, 1'b1, 16'h1111, 2'b01, 2'b01, 2'd2}, // R7 R5 wb then shared
    '{1'b1, 2'd2, 8'h04, 16'h0000, 1'b0, 16'h0000, 2'b01, 2'b00, 2'd0}, // R8 silent drop
    '{1'b0, 2'd1, 8'h05, 16'h3333, 1'b0, 16'h0000, 2'b10, 2'b00, 2'd1}, // R4 write miss
    '{1'b1, 2'd0, 8'h05, 16'h0000, 1'b1, 16'h3333, 2'b01, 2'b01, 2'd1}, // R5
    '{1'b0, 2'd1, 8'h05, 16'h4444, 1'b0, 16'h0000, 2'b10, 2'b00, 2'd1}  // R4 R6 from shared
  };

  function automatic string vtag(input int i);
    case (i)
      0, 6:             return "R3";
      1, 4, 16:         return "R5";
      2, 5, 15, 17:     return "R4";
      3, 7:             return "R2";
      14:               return "R8";
      default:          return "R7";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          a_valid, b_valid;
  logic [1:0]    a_op, b_op;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata;
  logic          a_ready, b_ready, a_done, b_done;
  logic [DW-1:0] a_rdata, b_rdata;
  logic          a_breq, b_breq;
  logic [1:0]    a_cmd, b_cmd;
  logic [AW-1:0] a_baddr, b_baddr;
  logic [DW-1:0] a_bdata, b_bdata;
  logic          a_gnt, b_gnt;
  logic [DW-1:0] a_resp, b_resp;
  logic          a_sh, b_sh, a_sup, b_sup;
  logic [DW-1:0] a_sdata, b_sdata;
  logic [AW-1:0] prb;
  logic [1:0]    a_pst, b_pst;
  logic          bus_en;
  logic          prio_b;
  logic [DW-1:0] mem [1<<AW];
  int            gcnt_a, gcnt_b;

  always_comb begin
    a_gnt  = bus_en && a_breq && (!b_breq || !prio_b);
    b_gnt  = bus_en && b_breq && !a_gnt;
    a_resp = b_sup ? b_sdata : mem[a_baddr];
    b_resp = a_sup ? a_sdata : mem[b_baddr];
  end

  always_ff @(posedge clk) begin
    if (a_gnt) begin
      gcnt_a <= gcnt_a + 1;
      if (a_cmd == 2'b11) mem[a_baddr] <= a_bdata;
      if (b_sup)          mem[a_baddr] <= b_sdata;
    end
    if (b_gnt) begin
      gcnt_b <= gcnt_b + 1;
      if (b_cmd == 2'b11) mem[b_baddr] <= b_bdata;
      if (a_sup)          mem[b_baddr] <= a_sdata;
    end
    if (a_gnt || b_gnt) prio_b <= a_gnt;
  end

  coh_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(a_valid), .cpu_op(a_op), .cpu_addr(a_addr), .cpu_wdata(a_wdata),
    .cpu_ready(a_ready), .cpu_done(a_done), .cpu_rdata(a_rdata),
    .bus_req_valid(a_breq), .bus_req_cmd(a_cmd), .bus_req_addr(a_baddr), .bus_req_data(a_bdata),
    .bus_ack(a_gnt), .bus_resp_data(a_resp), .bus_resp_shared(b_sh),
    .snp_valid(b_gnt), .snp_cmd(b_cmd), .snp_addr(b_baddr),
    .snp_shared(a_sh), .snp_supply(a_sup), .snp_data(a_sdata),
    .prb_addr(prb), .prb_state(a_pst)
  );

  coh_ctrl u_dut_b (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(b_valid), .cpu_op(b_op), .cpu_addr(b_addr), .cpu_wdata(b_wdata),
    .cpu_ready(b_ready), .cpu_done(b_done), .cpu_rdata(b_rdata),
    .bus_req_valid(b_breq), .bus_req_cmd(b_cmd), .bus_req_addr(b_baddr), .bus_req_data(b_bdata),
    .bus_ack(b_gnt), .bus_resp_data(b_resp), .bus_resp_shared(a_sh),
    .snp_valid(a_gnt), .snp_cmd(a_cmd), .snp_addr(a_baddr),
    .snp_shared(b_sh), .snp_supply(b_sup), .snp_data(b_sdata),
    .prb_addr(prb), .prb_state(b_pst)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic probe(input logic [AW-1:0] ad, output logic [1:0] sa, output logic [1:0] sb);
    prb = ad;
    #1;
    sa = a_pst;
    sb = b_pst;
  endtask

  task automatic run_op(input logic who, input logic [1:0] op, input logic [AW-1:0] ad,
                        input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                        output int nself, output int nother, output bit ok);
    int ga0, gb0;
    ga0 = gcnt_a;
    gb0 = gcnt_b;
    if (!who) begin a_valid = 1; a_op = op; a_addr = ad; a_wdata = wd; end
    else      begin b_valid = 1; b_op = op; b_addr = ad; b_wdata = wd; end
    @(negedge clk);
    a_valid = 0;
    b_valid = 0;
    ok = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if ((!who && a_done) || (who && b_done)) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    rd     = who ? b_rdata : a_rdata;
    nself  = who ? gcnt_b - gb0 : gcnt_a - ga0;
    nother = who ? gcnt_a - ga0 : gcnt_b - gb0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [1:0]    sa, sb;
    logic [DW-1:0] rd;
    int            ns, no;
    bit            ok;
    bit            inv_ok;

    a_valid = 0; b_valid = 0; a_op = 0; b_op = 0;
    a_addr = 0; b_addr = 0; a_wdata = 0; b_wdata = 0;
    prb = 0; bus_en = 1; prio_b = 0; gcnt_a = 0; gcnt_b = 0;
    for (int i = 0; i < (1 << AW); i++) mem[i] = 16'h1000 + DW'(i);
    repeat (3) @(negedge clk);

    // R1 reset state
    probe(8'h04, sa, sb);
    check("R1", "probe A after reset", 32'(sa), 32'h0);
    check("R1", "probe B after reset", 32'(sb), 32'h0);
    check("R1", "ready during reset", 32'({a_ready, b_ready}), 32'h3);
    rst_n = 1;
    @(negedge clk);
    probe(8'h3F, sa, sb);
    check("R1", "probe after release", 32'({sa, sb}), 32'h0);
    check("R1", "no bus request", 32'({a_breq, b_breq}), 32'h0);

    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v].who, VEC[v].op, VEC[v].addr, VEC[v].wdata, rd, ns, no, ok);
      check(vtag(v), $sformatf("vec %0d done", v), 32'(ok), 32'h1);
      if (VEC[v].chk_rd) check(vtag(v), $sformatf("vec %0d rdata", v), 32'(rd), 32'(VEC[v].exp_rd));
      check(vtag(v), $sformatf("vec %0d bus count", v), ns, 32'(VEC[v].exp_nbus));
      check("R6", $sformatf("vec %0d peer bus count", v), no, 0);
      probe(VEC[v].addr, sa, sb);
      check(vtag(v), $sformatf("vec %0d state A", v), 32'(sa), 32'(VEC[v].exp_sa));
      check(vtag(v), $sformatf("vec %0d state B", v), 32'(sb), 32'(VEC[v].exp_sb));
      check("R10", $sformatf("vec %0d exclusivity", v),
            32'((sa == 2'b10 && sb != 2'b00) || (sb == 2'b10 && sa != 2'b00)), 32'h0);
      @(negedge clk);
    end

    // R7 replaced frame of step 9 is gone from A
    probe(8'h08, sa, sb);
    check("R7", "replaced frame state A", 32'(sa), 32'h0);

    // R9 request waits while the bus withholds acknowledge
    bus_en = 0;
    a_valid = 1; a_op = 2'd0; a_addr = 8'h30; a_wdata = 0;
    @(negedge clk);
    a_valid = 0;
    repeat (5) @(negedge clk);
    check("R9", "ready low while waiting", 32'(a_ready), 32'h0);
    check("R9", "request held", 32'({a_breq, a_cmd}), 32'h5);
    check("R9", "no done while waiting", 32'(a_done), 32'h0);
    check("R9", "peer stays idle", 32'({b_ready, b_breq}), 32'h2);
    bus_en = 1;
    ok = 1'b0;
    for (int k = 0; k < 50; k++) begin
      if (a_done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    check("R9", "completes after acknowledge", 32'(ok), 32'h1);
    check("R9", "rdata after wait", 32'(a_rdata), 32'h1030);
    @(negedge clk);
    check("R9", "ready again", 32'(a_ready), 32'h1);

    // R10 sweep of the low address space
    inv_ok = 1'b1;
    for (int ad = 0; ad < 64; ad++) begin
      probe(AW'(ad), sa, sb);
      if ((sa == 2'b10 && sb != 2'b00) || (sb == 2'b10 && sa != 2'b00)) inv_ok = 1'b0;
    end
    check("R10", "exclusivity sweep", 32'(inv_ok), 32'h1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule